// File: doc/BRIEF.md
# CAN Serial Stuffing and CRC Engine

This block sits between a CAN frame sequencer and the bit-timing logic. It works on one bit per strobe. On the transmit side it takes frame bits from the sequencer, inserts a complementary bit after every run of five equal levels, and folds each frame bit into a 15-bit CRC. On the receive side it takes sampled bus bits, drops the complementary bit that follows each run of five, reports a sixth equal level as a stuff violation, and divides the remaining bits, the received CRC sequence included, so that a zero remainder marks a good frame.

The sequencer selects the direction with `tx_mode`. It raises `stuff_en` while the stuffed part of the frame is on the wire, which runs from the start-of-frame bit through the last CRC bit. It pulses `frame_start` before a new frame. In transmit mode `in_ready` drops for one strobe when a stuff bit is due. The strobe in that slot emits the stuff bit, and the sequencer holds its pending bit until the next strobe. To transmit the CRC, the sequencer sends `crc[14]` on each of the 15 strobes after the data field. That bit cancels the feedback, so the register shifts itself out and finishes at zero.

Top module: `can_stuff_crc`

## Requirements
- R1: The CRC register is 15 bits wide and uses the generator x^15+x^14+x^10+x^8+x^7+x^4+x^3+1 (feedback constant 0x4599). On each frame bit taken while `stuff_en` is high, it shifts left by one, MSB first, and XORs in 0x4599 whenever the bit XOR `crc[14]` is 1.
- R2: In transmit mode, once five consecutive output bits have had the same level (stuff bits included), `in_ready` goes low. The next strobe outputs the inverse level, and that stuff bit starts a new run. The destuffed input 1,0,0,0,0,0,1,1,1,1,1,0 therefore leaves as 1,0,0,0,0,0,1,1,1,1,1,0,1,0.
- R3: Stuff bits never change the CRC register, in either direction.
- R4: In receive mode with `stuff_en` high, the bit that follows five equal levels is not forwarded (no `out_valid`). It starts a new run with its own level.
- R5: In receive mode with `stuff_en` high, if the bit after five equal levels has that same level, `stuff_err` pulses for one cycle and the bit is not forwarded.
- R6: While `stuff_en` is low, every strobed bit is forwarded unchanged and the CRC does not change. The run counter is held at zero, so the first bit after `stuff_en` rises again starts a fresh run.
- R7: `frame_start` clears the CRC, the run count and any pending stuff bit. A strobe in the same cycle is treated as the first bit of the new frame.
- R8: `crc_ok` is high exactly when the CRC register is zero. It is high after a receiver has taken a whole stuffed frame including its correct CRC sequence, and after a transmitter has shifted out its CRC by sending `crc[14]` for 15 bits.
- R9: `out_valid`, `out_bit` and `stuff_err` are registered and appear in the cycle after the strobe. Every forwarded bit appears exactly once.
- R10: After reset, `out_valid` and `stuff_err` are 0, `crc` is 0, `crc_ok` is 1 and `in_ready` is 1.
- R11: In receive mode `in_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Clears CRC, run count and pending stuff bit |
| tx_mode | input | 1 | 1 = transmit (insert stuff bits), 0 = receive (remove stuff bits) |
| in_valid | input | 1 | Bit strobe, one per bit time |
| in_bit | input | 1 | Bit value (1 = recessive) |
| stuff_en | input | 1 | High while the current field is stuffed and CRC-covered |
| in_ready | output | 1 | Low in transmit mode when the next strobe carries a stuff bit |
| out_valid | output | 1 | Registered valid for out_bit |
| out_bit | output | 1 | Stuffed (transmit) or destuffed (receive) bit |
| stuff_err | output | 1 | One-cycle pulse on a sixth equal level in receive mode |
| crc | output | 15 | Running CRC register |
| crc_ok | output | 1 | High when crc is zero |

## Verification
A wrong run count moves a stuff bit. In transmit that shows at the ports as an early or late `in_ready` drop and an output stream that differs within the same strobe, long before any CRC check. In receive a bit is dropped or an extra bit is forwarded, so the destuffed bit sequence loses alignment at once. A CRC feedback fault cannot be seen bit by bit. It shows as a `crc` value that differs from an independently divided value at the end of the data field, and as `crc_ok` staying low after the full frame has been replayed into the receiver.

// File: rtl/can_stuff_crc.sv
module can_stuff_crc #(
  parameter int CRC_W = 15,
  parameter logic [CRC_W-1:0] POLY = 15'h4599,
  parameter int RUN_LEN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             tx_mode,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic             stuff_en,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_bit,
  output logic             stuff_err,
  output logic [CRC_W-1:0] crc,
  output logic             crc_ok
);

  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

  logic [RUN_W-1:0] run_q, run_b, run_n, run_inc;
  logic             last_q, last_n;
  logic             pend_q, pend_b, pend_n;
  logic [CRC_W-1:0] crc_b, crc_n;
  logic             ov_n, ob_n, err_n;
  logic             same, tx_stuff, rx_stuff;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    return {c[CRC_W-2:0], 1'b0} ^ ((b ^ c[CRC_W-1]) ? POLY : '0);
  endfunction

  assign run_b    = frame_start ? '0 : run_q;
  assign pend_b   = frame_start ? 1'b0 : pend_q;
  assign crc_b    = frame_start ? '0 : crc;
  assign same     = (run_b != '0) && (in_bit == last_q);
  assign run_inc  = same ? run_b + RUN_ONE : RUN_ONE;
  assign tx_stuff = tx_mode && pend_b;
  assign rx_stuff = !tx_mode && stuff_en && (run_b == RUN_MAX);
  assign in_ready = !(tx_mode && pend_q);
  assign crc_ok   = (crc == '0);

  always_comb begin
    run_n  = run_b;
    last_n = last_q;
    pend_n = pend_b;
    crc_n  = crc_b;
    ov_n   = 1'b0;
    ob_n   = out_bit;
    err_n  = 1'b0;
    if (in_valid) begin
      if (tx_stuff) begin
        ov_n   = 1'b1;
        ob_n   = !last_q;
        last_n = !last_q;
        run_n  = RUN_ONE;
        pend_n = 1'b0;
      end else if (rx_stuff) begin
        err_n  = (in_bit == last_q);
        last_n = in_bit;
        run_n  = RUN_ONE;
      end else if (stuff_en) begin
        ov_n   = 1'b1;
        ob_n   = in_bit;
        crc_n  = crc_step(crc_b, in_bit);
        last_n = in_bit;
        run_n  = run_inc;
        pend_n = tx_mode && (run_inc == RUN_MAX);
      end else begin
        ov_n   = 1'b1;
        ob_n   = in_bit;
        run_n  = '0;
        pend_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      last_q    <= 1'b1;
      pend_q    <= 1'b0;
      crc       <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b1;
      stuff_err <= 1'b0;
    end else begin
      run_q     <= run_n;
      last_q    <= last_n;
      pend_q    <= pend_n;
      crc       <= crc_n;
      out_valid <= ov_n;
      out_bit   <= ob_n;
      stuff_err <= err_n;
    end
  end

  assert_run_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX);

  assert_stall_emit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mode && !in_ready && in_valid && !frame_start
    |=> out_valid && in_ready && (out_bit != $past(out_bit)));

  assert_stuff_no_crc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mode && !in_ready && in_valid && !frame_start |=> $stable(crc));

  assert_rx_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_mode && in_valid && stuff_en && (run_q == RUN_MAX) && !frame_start |=> !out_valid);

  assert_err_not_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> !out_valid);

  assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !stuff_en && in_ready && !frame_start
    |=> out_valid && (out_bit == $past(in_bit)) && $stable(crc) && (run_q == '0));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !in_valid |=> (crc == '0) && in_ready);

  assert_rx_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_mode |-> in_ready);

endmodule

// File: tb/can_stuff_crc_test.sv
module can_stuff_crc_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, frame_start = 1'b0, tx_mode = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b1, stuff_en = 1'b0;
  logic in_ready, out_valid, out_bit, stuff_err, crc_ok;
  logic [14:0] crc;

  can_stuff_crc uut (.clk(clk), .rst_n(rst_n), .frame_start(frame_start), .tx_mode(tx_mode),
    .in_valid(in_valid), .in_bit(in_bit), .stuff_en(stuff_en), .in_ready(in_ready),
    .out_valid(out_valid), .out_bit(out_bit), .stuff_err(stuff_err), .crc(crc), .crc_ok(crc_ok));

  int checks = 0, errors = 0, err_pulses = 0, exp_err = 0;
  bit exp_q[$];
  bit stream[$];
  bit m_last = 1'b1, m_pend = 1'b0;
  int m_run = 0;
  logic [14:0] m_crc = '0;

  function automatic logic [14:0] ref_div(input logic [14:0] c, input bit b);
    logic [15:0] r;
    r = {c, 1'b0};
    if (b != c[14]) r = r ^ 16'hC599;
    return r[14:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: R9 every forwarded bit appears once, in order
  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R9", "unexpected output bit", out_bit, -1);
      else begin
        bit e;
        e = exp_q.pop_front();
        check(out_bit == e, "R2/R4/R9", "output bit", out_bit, e);
      end
    end
    if (stuff_err) err_pulses++;
  end

  task automatic strobe(input bit b, input bit sen, input bit fs);
    @(negedge clk);
    in_valid = 1'b1; in_bit = b; stuff_en = sen; frame_start = fs;
    @(negedge clk);
    in_valid = 1'b0; frame_start = 1'b0;
  endtask

  task automatic model_reset();
    m_run = 0; m_crc = '0; m_pend = 1'b0;
  endtask

  task automatic frame_clear();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    model_reset();
  endtask

  task automatic model_take(input bit b, input bit sen);
    if (sen) begin
      m_crc  = ref_div(m_crc, b);
      m_run  = (m_run > 0 && b == m_last) ? m_run + 1 : 1;
      m_last = b;
      m_pend = tx_mode && (m_run == 5);
    end else begin
      m_run = 0; m_pend = 1'b0;
    end
  endtask

  task automatic tx_send(input bit b, input bit sen, input bit fs = 1'b0);
    if (fs) model_reset();
    if (m_pend) begin
      check(!in_ready, "R2", "in_ready before stuff slot", in_ready, 0);
      exp_q.push_back(!m_last); stream.push_back(!m_last);
      strobe(b, sen, 1'b0);
      m_last = !m_last; m_run = 1; m_pend = 1'b0;
    end else if (!fs) check(in_ready, "R2", "in_ready on data slot", in_ready, 1);
    exp_q.push_back(b);
    if (sen) stream.push_back(b);
    strobe(b, sen, fs);
    model_take(b, sen);
  endtask

  task automatic rx_send(input bit b, input bit sen);
    if (sen && m_run == 5) begin
      if (b == m_last) exp_err++;
      m_run = 1; m_last = b;
      strobe(b, sen, 1'b0);
    end else begin
      exp_q.push_back(b);
      strobe(b, sen, 1'b0);
      model_take(b, sen);
    end
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9", "pending expected bits", exp_q.size(), 0);
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [39:0] pat;
    logic [14:0] saved;
    bit ex[12];
    bit want[14];
    int k;
    repeat (3) @(negedge clk);
    check(!out_valid && !stuff_err, "R10", "outputs after reset", {out_valid, stuff_err}, 0);
    check(crc == 0 && crc_ok, "R10", "crc after reset", crc, 0);
    check(in_ready, "R10", "in_ready during reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 worked example
    tx_mode = 1'b1; frame_clear(); stream.delete();
    ex = '{1,0,0,0,0,0,1,1,1,1,1,0};
    want = '{1,0,0,0,0,0,1,1,1,1,1,0,1,0};
    foreach (ex[i]) tx_send(ex[i], 1'b1);
    drain();
    check(stream.size() == 14, "R2", "stuffed length", stream.size(), 14);
    k = 0;
    foreach (want[i]) if (i < stream.size() && stream[i] != want[i]) k++;
    check(k == 0, "R2", "example mismatches", k, 0);
    check(crc == m_crc, "R1", "crc of example", crc, m_crc);

    // full transmit frame with CRC sequence
    frame_clear(); stream.delete();
    pat = 40'h07E03AC5F0;
    for (int i = 39; i >= 0; i--) tx_send(pat[i], 1'b1);
    drain();
    check(crc == m_crc, "R1", "crc after data field", crc, m_crc);
    check(crc == m_crc, "R3", "stuff bits excluded from crc", crc, m_crc);
    saved = m_crc;
    for (int i = 14; i >= 0; i--) tx_send(saved[i], 1'b1);
    drain();
    check(crc_ok && crc == 0, "R8", "tx crc shifted out", crc, 0);
    tx_send(1'b1, 1'b0);
    drain();

    // receive replay
    tx_mode = 1'b0; frame_clear();
    foreach (stream[i]) rx_send(stream[i], 1'b1);
    drain();
    check(crc_ok, "R8", "rx crc_ok after frame", crc, 0);
    check(err_pulses == exp_err, "R4", "no stuff error on clean frame", err_pulses, exp_err);

    // receive stuff error
    frame_clear();
    for (int i = 0; i < 5; i++) rx_send(1'b0, 1'b1);
    check(in_ready, "R11", "rx in_ready", in_ready, 1);
    rx_send(1'b0, 1'b1);
    drain();
    check(err_pulses == exp_err && exp_err == 1, "R5", "stuff error pulses", err_pulses, 1);

    // bypass with stuffing off
    frame_clear();
    for (int i = 0; i < 8; i++) rx_send(1'b0, 1'b0);
    drain();
    check(crc == 0 && err_pulses == 1, "R6", "rx bypass crc/err", crc, 0);
    tx_mode = 1'b1; frame_clear();
    for (int i = 0; i < 7; i++) tx_send(1'b1, 1'b0);
    check(in_ready, "R6", "no stuff in bypass", in_ready, 1);
    for (int i = 0; i < 4; i++) tx_send(1'b1, 1'b1);
    check(in_ready, "R6", "fresh run after bypass", in_ready, 1);
    drain();

    // frame_start with strobe
    frame_clear();
    for (int i = 0; i < 4; i++) tx_send(1'b0, 1'b1);
    tx_send(1'b0, 1'b1, 1'b1);
    check(crc == m_crc, "R7", "crc restarted with bit", crc, m_crc);
    for (int i = 0; i < 4; i++) tx_send(1'b0, 1'b1);
    check(!in_ready, "R7", "run counted from cleared frame", in_ready, 0);
    tx_send(1'b1, 1'b1);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule